// File: doc/BRIEF.md
# Programmable Baud Rate Generator

This block divides its input clock into a square-wave bit clock. The host loads a 16-bit time constant as two byte writes. A down counter runs from the constant, and an output flip-flop changes level each time the count runs out, which gives a half-period of the time constant plus two input clocks. A new constant is held back until the next reload, so a count that is already running is never cut short or stretched.

A second stage counts rising edges of the square wave and raises a one-cycle bit strobe once every 1, 16, 32 or 64 periods. This follows the clock-mode multiplier of the serial channel: 1 for synchronous links and 16, 32 or 64 for oversampled asynchronous links. The resulting rate is f_in / (2 × (TC + 2) × mode). While the enable is low the generator rests with its output high. Raising the enable starts a new run from a full count.

Top module: `brg_baud_gen`

## Requirements
- R1: After reset, `brg_out` is 1 and `bit_tick` is 0, and the time constant equals the parameter `TC_RESET`.
- R2: While `en` is low, `brg_out` stays 1, `bit_tick` stays 0 and the counter does not run.
- R3: When `en` is sampled high at clock edge e0 after being low, the first falling edge of `brg_out` comes at edge e0 + TC + 1.
- R4: After that, `brg_out` changes level every TC + 2 input clocks, and only when the count expires.
- R5: A `wr_lo` write only stages the low byte. A `wr_hi` write commits {`wr_data`, staged low byte} as the new time constant. A low-byte write on its own leaves the period unchanged.
- R6: A constant committed during a half-period does not change that half-period. It first applies to the half-period that begins at the next expiry.
- R7: A time constant of 0 gives a half-period of 2 input clocks.
- R8: `mode_sel` chooses the bit-strobe divisor: 2'b00 gives 1, 2'b01 gives 16, 2'b10 gives 32 and 2'b11 gives 64 rising edges of `brg_out` per strobe. The rising-edge count restarts from zero at each enable.
- R9: `bit_tick` is high for exactly one cycle, in the cycle right after the edge at which `brg_out` rises.
- R10: Dropping `en` in the middle of a count forces `brg_out` high one edge later. The next enable restarts from a full count.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Input clock that is divided |
| rst_n | input | 1 | Active-low asynchronous reset |
| en | input | 1 | Run enable; low parks the output high |
| wr_lo | input | 1 | Stage `wr_data` as the low byte of the constant |
| wr_hi | input | 1 | Commit `wr_data` as the high byte together with the staged low byte |
| wr_data | input | TC_W/2 | Byte written to the time constant |
| mode_sel | input | 2 | Bit-strobe divisor select (1/16/32/64) |
| brg_out | output | 1 | Square-wave baud clock |
| bit_tick | output | 1 | One-cycle strobe every 1/16/32/64 output periods |

## Verification
The bench builds the block with `TC_W` = 16 and `TC_RESET` = 5. A first run therefore exercises the reset constant without any write, and byte-wide writes can reach a constant above 255, where the high byte matters. Short constants (0, 3, 6) keep runs of 64 rising edges within a few hundred cycles, so every divisor setting is reached. A committed constant of 258 shows the deferred update on a half-period that is far longer than the one before it.

// File: rtl/brg_pkg.sv
package brg_pkg;

  localparam int MAX_DIV = 64;
  localparam int DIV_W   = $clog2(MAX_DIV);

  typedef enum logic [1:0] {
    MODE_X1  = 2'b00,
    MODE_X16 = 2'b01,
    MODE_X32 = 2'b10,
    MODE_X64 = 2'b11
  } brg_mode_e;

  // Number of rising output edges per bit strobe.
  function automatic logic [DIV_W:0] mode_divisor(input logic [1:0] sel);
    case (brg_mode_e'(sel))
      MODE_X1:  mode_divisor = (DIV_W+1)'(1);
      MODE_X16: mode_divisor = (DIV_W+1)'(16);
      MODE_X32: mode_divisor = (DIV_W+1)'(32);
      default:  mode_divisor = (DIV_W+1)'(64);
    endcase
  endfunction

endpackage

// File: rtl/brg_tc_regs.sv
module brg_tc_regs #(
  parameter int TC_W = 16,
  parameter logic [TC_W-1:0] TC_RESET = '0
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              wr_lo,
  input  logic              wr_hi,
  input  logic [TC_W/2-1:0] wr_data,
  output logic [TC_W-1:0]   tc_q
);
  localparam int BYTE_W = TC_W / 2;

  logic [BYTE_W-1:0] lo_stage;

  // The low byte waits in a stage; the full constant changes only on a high-byte write.
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      lo_stage <= TC_RESET[BYTE_W-1:0];
      tc_q     <= TC_RESET;
    end else begin
      if (wr_lo) lo_stage <= wr_data;
      if (wr_hi) tc_q <= {wr_data, lo_stage};
    end
  end
endmodule

// File: rtl/brg_down_counter.sv
module brg_down_counter #(
  parameter int TC_W = 16
) (
  input  logic            clk,
  input  logic            rst_n,
  input  logic            en,
  input  logic [TC_W-1:0] tc,
  output logic [TC_W:0]   cnt_q,
  output logic            out_q,
  output logic            expire
);
  // Reload value TC+1 plus the expiry cycle gives TC+2 clocks per half-period.
  function automatic logic [TC_W:0] reload_value(input logic [TC_W-1:0] t);
    reload_value = {1'b0, t} + (TC_W+1)'(1);
  endfunction

  assign expire = en && (cnt_q == '0);

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      cnt_q <= '0;
      out_q <= 1'b1;
    end else if (!en) begin
      cnt_q <= reload_value(tc);
      out_q <= 1'b1;
    end else if (expire) begin
      cnt_q <= reload_value(tc);
      out_q <= ~out_q;
    end else begin
      cnt_q <= cnt_q - (TC_W+1)'(1);
    end
  end
endmodule

// File: rtl/brg_mode_div.sv
module brg_mode_div
  import brg_pkg::*;
(
  input  logic       clk,
  input  logic       rst_n,
  input  logic       en,
  input  logic       rise,
  input  logic [1:0] mode_sel,
  output logic       tick_q
);
  logic [DIV_W:0] div_cnt;
  logic [DIV_W:0] last;

  assign last = mode_divisor(mode_sel) - (DIV_W+1)'(1);

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      div_cnt <= '0;
      tick_q  <= 1'b0;
    end else if (!en) begin
      div_cnt <= '0;
      tick_q  <= 1'b0;
    end else if (rise) begin
      if (div_cnt >= last) begin
        div_cnt <= '0;
        tick_q  <= 1'b1;
      end else begin
        div_cnt <= div_cnt + (DIV_W+1)'(1);
        tick_q  <= 1'b0;
      end
    end else begin
      tick_q <= 1'b0;
    end
  end
endmodule

// File: rtl/brg_baud_gen.sv
module brg_baud_gen #(
  parameter int TC_W = 16,
  parameter logic [TC_W-1:0] TC_RESET = 16'd14
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              en,
  input  logic              wr_lo,
  input  logic              wr_hi,
  input  logic [TC_W/2-1:0] wr_data,
  input  logic [1:0]        mode_sel,
  output logic              brg_out,
  output logic              bit_tick
);
  // Named internal events for the checker
  logic [TC_W-1:0] tc_active;
  logic [TC_W:0]   cnt_q;
  logic            expire;
  logic            rise_evt;

  brg_tc_regs #(.TC_W(TC_W), .TC_RESET(TC_RESET)) u_regs (
    .clk(clk), .rst_n(rst_n), .wr_lo(wr_lo), .wr_hi(wr_hi),
    .wr_data(wr_data), .tc_q(tc_active)
  );

  brg_down_counter #(.TC_W(TC_W)) u_cnt (
    .clk(clk), .rst_n(rst_n), .en(en), .tc(tc_active),
    .cnt_q(cnt_q), .out_q(brg_out), .expire(expire)
  );

  assign rise_evt = expire && !brg_out;

  brg_mode_div u_div (
    .clk(clk), .rst_n(rst_n), .en(en), .rise(rise_evt),
    .mode_sel(mode_sel), .tick_q(bit_tick)
  );
endmodule

// File: rtl/brg_baud_gen_chk.sv
module brg_baud_gen_chk #(
  parameter int TC_W = 16
) (
  input logic            clk,
  input logic            rst_n,
  input logic            en,
  input logic            wr_lo,
  input logic            wr_hi,
  input logic            brg_out,
  input logic            bit_tick,
  input logic            expire,
  input logic [TC_W:0]   cnt_q,
  input logic [TC_W-1:0] tc_active
);
  a_r2_idle_high: assert property (@(posedge clk) disable iff (!rst_n)
    !en |=> (brg_out && !bit_tick));

  a_r4_toggle_on_expire: assert property (@(posedge clk) disable iff (!rst_n)
    expire |=> (brg_out != $past(brg_out)));

  a_r4_hold_between: assert property (@(posedge clk) disable iff (!rst_n)
    (en && !expire) |=> $stable(brg_out));

  a_r6_count_undisturbed: assert property (@(posedge clk) disable iff (!rst_n)
    (en && !expire) |=> (cnt_q == $past(cnt_q) - (TC_W+1)'(1)));

  a_r5_lo_no_commit: assert property (@(posedge clk) disable iff (!rst_n)
    (wr_lo && !wr_hi) |=> $stable(tc_active));

  a_r9_tick_on_rise: assert property (@(posedge clk) disable iff (!rst_n)
    bit_tick |-> $rose(brg_out));

  a_r9_tick_single: assert property (@(posedge clk) disable iff (!rst_n)
    bit_tick |=> !bit_tick);
endmodule

bind brg_baud_gen brg_baud_gen_chk #(.TC_W(TC_W)) u_chk (
  .clk(clk), .rst_n(rst_n), .en(en), .wr_lo(wr_lo), .wr_hi(wr_hi),
  .brg_out(brg_out), .bit_tick(bit_tick), .expire(expire),
  .cnt_q(cnt_q), .tc_active(tc_active)
);

// File: tb/test_brg_baud_gen.sv
`timescale 1ns/1ps
module test_brg_baud_gen;
  localparam int TC_W = 16;
  localparam logic [TC_W-1:0] TC_RST = 16'd5;

  logic clk = 1'b0;
  logic rst_n = 1'b0;
  logic en = 1'b0, wr_lo = 1'b0, wr_hi = 1'b0;
  logic [7:0] wr_data = '0;
  logic [1:0] mode_sel = 2'b00;
  logic brg_out, bit_tick;

  int cyc = 0;
  int checks = 0, errors = 0;
  bit mon_on = 1'b0;
  logic prev_out = 1'b1;
  bit done = 1'b0;

  int edge_cyc[$];
  bit edge_lvl[$];
  int tick_cyc[$];

  always #2 clk = ~clk;

  brg_baud_gen #(.TC_W(TC_W), .TC_RESET(TC_RST)) i_brg_baud_gen (
    .clk(clk), .rst_n(rst_n), .en(en), .wr_lo(wr_lo), .wr_hi(wr_hi),
    .wr_data(wr_data), .mode_sel(mode_sel), .brg_out(brg_out), .bit_tick(bit_tick)
  );

  always @(posedge clk) cyc <= cyc + 1;

  task automatic chk(input bit ok, input string req, input string what,
                     input int act, input int exp);
    checks++;
    if (!ok) begin
      errors++;
      $display("FAIL %s %s actual=%0d expected=%0d", req, what, act, exp);
    end
  endtask

  // Monitor: pop expected edges and strobes as they appear
  always @(negedge clk) begin
    if (mon_on) begin
      if (brg_out !== prev_out) begin
        if (edge_cyc.size() == 0) chk(0, "R4", "unexpected edge at cycle", cyc, -1);
        else begin
          int ec; bit el;
          ec = edge_cyc.pop_front(); el = edge_lvl.pop_front();
          chk(ec == cyc, "R4", "edge cycle", cyc, ec);
          chk(el == brg_out, "R4", "edge level", int'(brg_out), int'(el));
        end
      end
      if (bit_tick === 1'b1) begin
        if (tick_cyc.size() == 0) chk(0, "R8", "unexpected bit_tick at cycle", cyc, -1);
        else begin
          int tc_;
          tc_ = tick_cyc.pop_front();
          chk(tc_ == cyc, "R9", "bit_tick cycle", cyc, tc_);
        end
      end
    end
    prev_out = brg_out;
  end

  function automatic int divisor(input logic [1:0] ms);
    case (ms)
      2'b00: return 1;
      2'b01: return 16;
      2'b10: return 32;
      default: return 64;
    endcase
  endfunction

  // Driver side: expected edge i (1-based) of a run, with its strobe if due
  task automatic push_edge(input int c, input int i, input int div);
    edge_cyc.push_back(c);
    edge_lvl.push_back(i % 2 == 0);
    if ((i % 2 == 0) && (((i / 2) % div) == 0)) tick_cyc.push_back(c);
  endtask

  task automatic wait_cyc(input int n);
    while (cyc < n) begin @(posedge clk); #1; end
  endtask

  task automatic write_tc(input logic [15:0] v);
    wr_lo = 1'b1; wr_data = v[7:0];
    @(posedge clk); #1;
    wr_lo = 1'b0; wr_hi = 1'b1; wr_data = v[15:8];
    @(posedge clk); #1;
    wr_hi = 1'b0;
  endtask

  task automatic end_run();
    mon_on = 1'b0;
    chk(edge_cyc.size() == 0, "R4", "edges not seen", edge_cyc.size(), 0);
    chk(tick_cyc.size() == 0, "R8", "strobes not seen", tick_cyc.size(), 0);
    edge_cyc.delete(); edge_lvl.delete(); tick_cyc.delete();
    en = 1'b0;
    @(posedge clk); #1;
    @(posedge clk); #1;
    chk(brg_out === 1'b1, "R2", "output after disable", int'(brg_out), 1);
  endtask

  // R3/R4: expected edges at p + L*i with L = TC + 2
  task automatic start_run(input int tc, input logic [1:0] ms, input int nh);
    int L, p, div;
    L = tc + 2; div = divisor(ms);
    mode_sel = ms;
    @(posedge clk); #1;
    p = cyc;
    for (int i = 1; i <= nh; i++) push_edge(p + L * i, i, div);
    mon_on = 1'b1;
    en = 1'b1;
    wait_cyc(p + L * nh + 1);
    end_run();
  endtask

  // R5/R6: low-byte-only write has no effect; committed constant waits for next expiry
  task automatic run_change(input int ta, input logic [15:0] tb);
    int la, lb, p;
    la = ta + 2; lb = int'(tb) + 2;
    mode_sel = 2'b00;
    @(posedge clk); #1;
    p = cyc;
    push_edge(p + la, 1, 1);
    push_edge(p + 2 * la, 2, 1);
    for (int i = 3; i <= 5; i++) push_edge(p + 2 * la + lb * (i - 2), i, 1);
    mon_on = 1'b1;
    en = 1'b1;
    wait_cyc(p + 2);
    wr_lo = 1'b1; wr_data = 8'hFF;
    @(posedge clk); #1;
    wr_lo = 1'b0;
    wait_cyc(p + la + 1);
    write_tc(tb);
    wait_cyc(p + 2 * la + lb * 3 + 1);
    end_run();
  endtask

  task automatic report();
    $display("  CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  endtask

  initial begin
    repeat (100000) @(posedge clk);
    if (!done) begin
      errors++;
      checks++;
      $display("FAIL watchdog expired at cycle %0d", cyc);
      report();
    end
  end

  initial begin
    repeat (3) @(posedge clk);
    #1;
    chk(brg_out === 1'b1, "R1", "brg_out in reset", int'(brg_out), 1);
    chk(bit_tick === 1'b0, "R1", "bit_tick in reset", int'(bit_tick), 0);
    rst_n = 1'b1;
    @(posedge clk); #1;
    chk(brg_out === 1'b1, "R1", "brg_out after reset", int'(brg_out), 1);

    // R1/R3/R4: reset constant, no write
    start_run(int'(TC_RST), 2'b00, 6);

    // R7: zero constant
    write_tc(16'd0);
    start_run(0, 2'b00, 8);

    // R8: each divisor setting
    write_tc(16'd3);
    start_run(3, 2'b01, 34);
    write_tc(16'd0);
    start_run(0, 2'b10, 66);
    start_run(0, 2'b11, 130);

    // R5/R6: deferred update with high byte in use
    write_tc(16'd10);
    run_change(10, 16'h0102);

    // R10: drop enable mid-count, then R2 idle
    write_tc(16'd6);
    mode_sel = 2'b00;
    @(posedge clk); #1;
    begin
      int p;
      p = cyc;
      en = 1'b1;
      wait_cyc(p + 8 + 2);
      chk(brg_out === 1'b0, "R3", "output low after first expiry", int'(brg_out), 0);
      en = 1'b0;
      @(posedge clk); #1;
      chk(brg_out === 1'b1, "R10", "output forced high after disable", int'(brg_out), 1);
    end
    for (int k = 0; k < 20; k++) begin
      @(posedge clk); #1;
      chk(brg_out === 1'b1 && bit_tick === 1'b0, "R2", "idle output/strobe",
          int'({brg_out, bit_tick}), 2);
    end
    // R10: restart from full count
    start_run(6, 2'b00, 4);

    done = 1'b1;
    report();
  end
endmodule